// File: doc/BRIEF.md
# Chunked Instruction Queue Fetcher

This block walks a command queue that lives in memory as a chain of fixed-size buffer segments. Every segment holds a whole number of 64-byte instructions, followed by one 64-bit word that holds the address of the next segment. The fetcher issues one line-sized read per instruction while the queue is enabled and the doorbell has granted at least one instruction's worth of credit. It forwards the eight returned words on an instruction stream. After the last instruction of a segment it reads the trailing pointer word and continues from the address found there.

The block counts instructions from the moment their fetch is accepted until a completion pulse retires them. Software watches this count before it reconfigures the queue. When the chunk-free option is on, finishing a segment announces that segment's line address so that its buffer can be returned to a pool. The block keeps one memory request outstanding at a time. Software may change the base address only while the queue is disabled.

Top module: `cmdq_fetch`

## Requirements
- R1: After reset no read request is raised, the in-flight count is 0, the readback line is 0 and no free notification is raised.
- R2: An instruction read is raised only while `cfg_enable` is 1 and the credit is at least 8 words. Each accepted instruction read removes 8 words of credit, and each doorbell pulse adds `db_words`. Starting from zero credit, `db_words` = 8c gives exactly c instruction reads.
- R3: Instruction reads have `rd_req_is_ptr` = 0 and go to consecutive 64-byte lines, starting at the segment's base line. The byte address is the line number shifted left by 6.
- R4: The number of instructions per segment is n = `cfg_seg_words` >> 3, where `cfg_seg_words` = 8n+1. After the n-th instruction of a segment, one pointer read (`rd_req_is_ptr` = 1) goes to line base+n. This read needs no credit.
- R5: Bits [48:6] of the pointer word become the new segment base line and the next line to fetch. Bits [63:49] and [5:0] are ignored.
- R6: Each instruction read is answered by 8 response beats. These appear on `inst_valid`/`inst_data` in the same cycle as the response, with `inst_last` high on the eighth beat only.
- R7: The in-flight count rises by 1 on each accepted instruction read and falls by 1 on each `done_pulse`. A pulse at a count of 0 is ignored. No instruction read is raised while the count is 255.
- R8: After `cfg_enable` is cleared, an instruction whose read is already raised completes, and no further instruction read is raised.
- R9: `cfg_next_line` shows the next line to be fetched. A `cfg_base_wr` pulse loads it only while the queue is disabled and idle. While the queue is enabled, the pulse has no effect.
- R10: With `cfg_free_mode` = 1, one cycle after a pointer response `free_valid` pulses for one cycle and `free_line` gives the finished segment's base line. With the mode at 0, no pulse occurs.
- R11: A raised read request keeps its address and kind unchanged until `rd_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Queue enable |
| cfg_base_wr | input | 1 | Load base line (honoured when disabled and idle) |
| cfg_base_line | input | 43 | Segment base, address bits [48:6] |
| cfg_seg_words | input | 13 | Segment size in 64-bit words (8n+1) |
| cfg_free_mode | input | 1 | Announce finished segments |
| cfg_next_line | output | 43 | Next line to be fetched |
| db_valid | input | 1 | Doorbell pulse |
| db_words | input | 20 | Words of credit to add |
| rd_req_valid | output | 1 | Read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 49 | Byte address of the read |
| rd_req_is_ptr | output | 1 | 1 = next-segment pointer read, 0 = instruction read |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_data | input | 64 | Response beat data |
| inst_valid | output | 1 | Instruction word valid |
| inst_data | output | 64 | Instruction word |
| inst_last | output | 1 | Eighth word of an instruction |
| done_pulse | input | 1 | One instruction retired |
| inflight_count | output | 8 | Instructions in flight |
| free_valid | output | 1 | Finished-segment notification |
| free_line | output | 43 | Base line of the finished segment |

## Verification
A request raised while `rd_req_ready` is high is accepted at the next rising edge. The bench reads valid, address and kind at the falling edge before that edge and compares them with an arithmetic model of the segment chain. The response beats are driven at the falling edges that follow acceptance. Because the instruction stream is combinational, each beat is checked 1 ns after it is driven. The free pulse is due one edge after the pointer beat is captured, so the bench looks for it at the next falling edge. In-flight, credit and readback values settle one edge after their cause, and the bench checks them only after the queue has been quiet for a margin of cycles.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INST_REQ,
        ST_INST_RSP,
        ST_PTR_REQ,
        ST_PTR_RSP
    } fetch_st_e;

    localparam int unsigned LINE_BYTES_LOG2 = 6;
    localparam int unsigned WORDS_PER_INST  = 8;

endpackage

// File: rtl/cmdq_credit.sv
module cmdq_credit #(
    parameter int unsigned CREDIT_W  = 20,
    parameter int unsigned INST_WDS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add_valid,
    input  logic [CREDIT_W-1:0] add_words,
    input  logic                take,
    output logic                avail
);

    localparam logic [CREDIT_W-1:0] STEP = CREDIT_W'(INST_WDS);

    typedef struct packed {
        logic [CREDIT_W-1:0] words;
    } credit_t;

    credit_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (add_valid) begin
            s_d.words = s_d.words + add_words;
        end
        if (take) begin
            s_d.words = s_d.words - STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign avail = (s_q.words >= STEP);

endmodule

// File: rtl/cmdq_inflight.sv
module cmdq_inflight #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic dec_ok;

    always_comb begin
        s_d    = s_q;
        dec_ok = dec && (s_q.cnt != '0);
        unique case ({inc, dec_ok})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;
    assign full  = (s_q.cnt == '1);

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
    import cmdq_pkg::*;
#(
    parameter int unsigned ADDR_W = 49,
    parameter int unsigned SEG_W  = 13,
    parameter int unsigned DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_base_wr,
    input  logic [ADDR_W-7:0]   cfg_base_line,
    input  logic [SEG_W-1:0]    cfg_seg_words,
    input  logic                cfg_free_mode,
    input  logic                credit_avail,
    input  logic                inflight_full,
    input  logic                rd_req_ready,
    input  logic                rd_rsp_valid,
    input  logic [DATA_W-1:0]   rd_rsp_data,
    output logic                rd_req_valid,
    output logic [ADDR_W-7:0]   rd_req_line,
    output logic                rd_req_is_ptr,
    output logic                inst_take,
    output logic                inst_valid,
    output logic                inst_last,
    output logic                free_valid,
    output logic [ADDR_W-7:0]   free_line,
    output logic [ADDR_W-7:0]   next_line
);

    localparam int unsigned LINE_W = ADDR_W - LINE_BYTES_LOG2;
    localparam int unsigned IDX_W  = SEG_W - 3;
    localparam int unsigned BEAT_W = $clog2(WORDS_PER_INST);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS_PER_INST - 1);

    typedef struct packed {
        fetch_st_e         st;
        logic [LINE_W-1:0] cur_line;
        logic [LINE_W-1:0] seg_line;
        logic [IDX_W-1:0]  idx;
        logic [BEAT_W-1:0] beat;
        logic              free_v;
        logic [LINE_W-1:0] free_l;
    } seq_t;

    seq_t s_d, s_q;
    logic [IDX_W-1:0] per_seg;
    logic [IDX_W-1:0] idx_inc;

    assign per_seg = cfg_seg_words[SEG_W-1:3];
    assign idx_inc = s_q.idx + IDX_W'(1);

    always_comb begin
        s_d        = s_q;
        s_d.free_v = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cfg_base_wr && !cfg_enable) begin
                    s_d.cur_line = cfg_base_line;
                    s_d.seg_line = cfg_base_line;
                    s_d.idx      = '0;
                end else if (cfg_enable) begin
                    if (s_q.idx == per_seg) begin
                        s_d.st = ST_PTR_REQ;
                    end else if (credit_avail && !inflight_full) begin
                        s_d.st = ST_INST_REQ;
                    end
                end
            end
            ST_INST_REQ: begin
                if (rd_req_ready) begin
                    s_d.cur_line = s_q.cur_line + LINE_W'(1);
                    s_d.beat     = '0;
                    s_d.st       = ST_INST_RSP;
                end
            end
            ST_INST_RSP: begin
                if (rd_rsp_valid) begin
                    s_d.beat = s_q.beat + BEAT_W'(1);
                    if (s_q.beat == LAST_BEAT) begin
                        s_d.idx = idx_inc;
                        s_d.st  = (idx_inc == per_seg) ? ST_PTR_REQ : ST_IDLE;
                    end
                end
            end
            ST_PTR_REQ: begin
                if (rd_req_ready) begin
                    s_d.st = ST_PTR_RSP;
                end
            end
            ST_PTR_RSP: begin
                if (rd_rsp_valid) begin
                    s_d.cur_line = rd_rsp_data[ADDR_W-1:LINE_BYTES_LOG2];
                    s_d.seg_line = rd_rsp_data[ADDR_W-1:LINE_BYTES_LOG2];
                    s_d.idx      = '0;
                    s_d.free_v   = cfg_free_mode;
                    s_d.free_l   = s_q.seg_line;
                    s_d.st       = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req_valid  = (s_q.st == ST_INST_REQ) || (s_q.st == ST_PTR_REQ);
    assign rd_req_is_ptr = (s_q.st == ST_PTR_REQ);
    assign rd_req_line   = s_q.cur_line;
    assign inst_take     = (s_q.st == ST_INST_REQ) && rd_req_ready;
    assign inst_valid    = (s_q.st == ST_INST_RSP) && rd_rsp_valid;
    assign inst_last     = inst_valid && (s_q.beat == LAST_BEAT);
    assign free_valid    = s_q.free_v;
    assign free_line     = s_q.free_l;
    assign next_line     = s_q.cur_line;

endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
    import cmdq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 49,
    parameter int unsigned SEG_W    = 13,
    parameter int unsigned CREDIT_W = 20,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned DATA_W   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_base_wr,
    input  logic [ADDR_W-7:0]   cfg_base_line,
    input  logic [SEG_W-1:0]    cfg_seg_words,
    input  logic                cfg_free_mode,
    output logic [ADDR_W-7:0]   cfg_next_line,
    input  logic                db_valid,
    input  logic [CREDIT_W-1:0] db_words,
    output logic                rd_req_valid,
    input  logic                rd_req_ready,
    output logic [ADDR_W-1:0]   rd_req_addr,
    output logic                rd_req_is_ptr,
    input  logic                rd_rsp_valid,
    input  logic [DATA_W-1:0]   rd_rsp_data,
    output logic                inst_valid,
    output logic [DATA_W-1:0]   inst_data,
    output logic                inst_last,
    input  logic                done_pulse,
    output logic [CNT_W-1:0]    inflight_count,
    output logic                free_valid,
    output logic [ADDR_W-7:0]   free_line
);

    localparam int unsigned LINE_W = ADDR_W - LINE_BYTES_LOG2;

    logic              credit_avail_w;
    logic              inflight_full_w;
    logic              inst_take_w;
    logic [LINE_W-1:0] req_line_w;

    cmdq_credit #(
        .CREDIT_W (CREDIT_W),
        .INST_WDS (WORDS_PER_INST)
    ) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_valid (db_valid),
        .add_words (db_words),
        .take      (inst_take_w),
        .avail     (credit_avail_w)
    );

    cmdq_inflight #(
        .CNT_W (CNT_W)
    ) u_inflight (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inst_take_w),
        .dec   (done_pulse),
        .count (inflight_count),
        .full  (inflight_full_w)
    );

    cmdq_seq #(
        .ADDR_W (ADDR_W),
        .SEG_W  (SEG_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enable    (cfg_enable),
        .cfg_base_wr   (cfg_base_wr),
        .cfg_base_line (cfg_base_line),
        .cfg_seg_words (cfg_seg_words),
        .cfg_free_mode (cfg_free_mode),
        .credit_avail  (credit_avail_w),
        .inflight_full (inflight_full_w),
        .rd_req_ready  (rd_req_ready),
        .rd_rsp_valid  (rd_rsp_valid),
        .rd_rsp_data   (rd_rsp_data),
        .rd_req_valid  (rd_req_valid),
        .rd_req_line   (req_line_w),
        .rd_req_is_ptr (rd_req_is_ptr),
        .inst_take     (inst_take_w),
        .inst_valid    (inst_valid),
        .inst_last     (inst_last),
        .free_valid    (free_valid),
        .free_line     (free_line),
        .next_line     (cfg_next_line)
    );

    assign rd_req_addr = {req_line_w, {LINE_BYTES_LOG2{1'b0}}};
    assign inst_data   = rd_rsp_data;

endmodule

// File: rtl/cmdq_fetch_chk.sv
module cmdq_fetch_chk #(
    parameter int unsigned ADDR_W = 49,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              rd_req_is_ptr,
    input logic              done_pulse,
    input logic [CNT_W-1:0]  inflight_count,
    input logic              free_valid,
    input logic              cfg_free_mode,
    input logic              credit_avail
);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=>
            rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_is_ptr));

    a_r2_credit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_is_ptr |-> credit_avail);

    a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && rd_req_ready && !rd_req_is_ptr && !done_pulse |=>
            inflight_count == $past(inflight_count) + CNT_W'(1));

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_count == '1 |=> inflight_count != '0);

    a_r10_free_gate: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> $past(cfg_free_mode));

endmodule

bind cmdq_fetch cmdq_fetch_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_req_valid   (rd_req_valid),
    .rd_req_ready   (rd_req_ready),
    .rd_req_addr    (rd_req_addr),
    .rd_req_is_ptr  (rd_req_is_ptr),
    .done_pulse     (done_pulse),
    .inflight_count (inflight_count),
    .free_valid     (free_valid),
    .cfg_free_mode  (cfg_free_mode),
    .credit_avail   (credit_avail_w)
);

// File: tb/cmdq_fetch_test.sv
module cmdq_fetch_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [42:0] BASE0 = 43'h40;
    localparam logic [42:0] HOP   = 43'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_base_wr = 1'b0;
    logic [42:0] cfg_base_line = '0;
    logic [12:0] cfg_seg_words = 13'd9;
    logic        cfg_free_mode = 1'b0;
    logic [42:0] cfg_next_line;
    logic        db_valid = 1'b0;
    logic [19:0] db_words = '0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b1;
    logic [48:0] rd_req_addr;
    logic        rd_req_is_ptr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        inst_valid;
    logic [63:0] inst_data;
    logic        inst_last;
    logic        done_pulse = 1'b0;
    logic [7:0]  inflight_count;
    logic        free_valid;
    logic [42:0] free_line;

    cmdq_fetch uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model of the segment chain
    logic [42:0] exp_line, exp_seg, exp_free, rsp_line, rsp_next;
    int exp_idx, n_cur, beats_left, beat_no;
    int n_inst, n_ptr, n_free, cyc;
    bit rsp_is_ptr, stall;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (beats_left > 0) begin
            rd_rsp_valid = 1'b1;
            if (rsp_is_ptr) rd_rsp_data = {15'h2d2d, rsp_next, 6'h2b};
            else            rd_rsp_data = {13'h0, rsp_line, 8'(beat_no)};
        end else begin
            rd_rsp_valid = 1'b0;
            rd_rsp_data  = '0;
        end
        rd_req_ready = stall ? ((cyc % 3) != 0) : 1'b1;
        #1;
        if (beats_left > 0) begin
            if (!rsp_is_ptr) begin
                // R6: beats pass through, last flag on eighth
                chk(inst_valid === 1'b1 && inst_data === rd_rsp_data && inst_last === (beat_no == 7),
                    "R6 inst beat", {inst_valid, inst_last, inst_data[61:0]},
                    {1'b1, (beat_no == 7), rd_rsp_data[61:0]});
            end
            beats_left--;
            beat_no++;
        end
        if (free_valid === 1'b1) begin
            // R10: notification carries the finished segment
            chk(cfg_free_mode && free_line == exp_free, "R10 free line", 64'(free_line), 64'(exp_free));
            n_free++;
        end
        if (rd_req_valid === 1'b1 && rd_req_ready) begin
            if (!rd_req_is_ptr) begin
                // R3: consecutive lines from segment base
                chk(exp_idx < n_cur && rd_req_addr == {exp_line, 6'b0}, "R3 inst addr",
                    64'(rd_req_addr), 64'({exp_line, 6'b0}));
                rsp_line   = exp_line;
                rsp_is_ptr = 1'b0;
                beats_left = 8;
                beat_no    = 0;
                exp_line   = exp_line + 43'd1;
                exp_idx++;
                n_inst++;
            end else begin
                // R4: pointer read at base+n after n instructions
                chk(exp_idx == n_cur && rd_req_addr == {exp_line, 6'b0}, "R4 ptr addr",
                    64'(rd_req_addr), 64'({exp_line, 6'b0}));
                rsp_next   = exp_seg + HOP;
                rsp_is_ptr = 1'b1;
                beats_left = 1;
                beat_no    = 0;
                exp_free   = exp_seg;
                // R5: only bits [48:6] of the pointer word are used
                exp_seg    = exp_seg + HOP;
                exp_line   = exp_seg;
                exp_idx    = 0;
                n_ptr++;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int n, input bit fm, input bit st);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_enable = 1'b0;
        cfg_free_mode = fm;
        cfg_seg_words = 13'(8 * n + 1);
        stall = st;
        n_cur = n;
        exp_line = BASE0; exp_seg = BASE0; exp_free = '0; exp_idx = 0;
        n_inst = 0; n_ptr = 0; n_free = 0; beats_left = 0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_base_wr = 1'b1;
        cfg_base_line = BASE0;
        @(negedge clk);
        cfg_base_wr = 1'b0;
    endtask

    task automatic ring(input int insts);
        db_valid = 1'b1;
        db_words = 20'(8 * insts);
        @(negedge clk);
        db_valid = 1'b0;
        db_words = '0;
    endtask

    task automatic retire(input int k);
        for (int i = 0; i < k; i++) begin
            done_pulse = 1'b1;
            @(negedge clk);
            done_pulse = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        cyc = 0; stall = 1'b0; beats_left = 0; n_cur = 1;
        exp_line = BASE0; exp_seg = BASE0; exp_free = '0;
        // R1: reset state
        idle(3);
        #2;
        chk(rd_req_valid === 1'b0, "R1 req idle", 64'(rd_req_valid), 0);
        chk(inflight_count === 8'd0, "R1 inflight", 64'(inflight_count), 0);
        chk(cfg_next_line === 43'd0, "R1 readback", 64'(cfg_next_line), 0);
        chk(free_valid === 1'b0, "R1 free", 64'(free_valid), 0);

        // R7: completion at zero is ignored
        setup(1, 1'b0, 1'b0);
        retire(1);
        idle(2);
        chk(inflight_count == 8'd0, "R7 done at zero", 64'(inflight_count), 0);

        // sweep segment sizes and credits
        for (int n = 1; n <= 3; n++) begin
            for (int k = 0; k < 5; k++) begin
                int c;
                c = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? n : (k == 3) ? n + 1 : 2 * n + 1;
                setup(n, k[0], n[0] ^ k[1]);
                cfg_enable = 1'b1;
                ring(c);
                idle(30 * c + 40);
                chk(n_inst == c, "R2 inst count", 64'(n_inst), 64'(c));
                chk(n_ptr == c / n, "R4 ptr count", 64'(n_ptr), 64'(c / n));
                chk(n_free == (k[0] ? c / n : 0), "R10 free count", 64'(n_free), 64'(k[0] ? c / n : 0));
                chk(cfg_next_line == exp_line, "R9 readback", 64'(cfg_next_line), 64'(exp_line));
                chk(inflight_count == 8'(c), "R7 inflight up", 64'(inflight_count), 64'(c));
                retire(c);
                idle(2);
                chk(inflight_count == 8'd0, "R7 inflight down", 64'(inflight_count), 0);
            end
        end

        // R2: credit without enable does nothing; R8: disable mid-flight
        setup(4, 1'b0, 1'b0);
        ring(4);
        idle(20);
        chk(n_inst == 0, "R2 no enable", 64'(n_inst), 0);
        cfg_enable = 1'b1;
        while (rd_req_valid !== 1'b1) @(negedge clk);
        cfg_enable = 1'b0;
        idle(60);
        chk(n_inst == 1, "R8 stop after current", 64'(n_inst), 1);
        chk(cfg_next_line == BASE0 + 43'd1, "R8 readback", 64'(cfg_next_line), 64'(BASE0 + 43'd1));

        // R9: base write ignored while enabled
        setup(2, 1'b0, 1'b0);
        cfg_enable = 1'b1;
        idle(2);
        cfg_base_wr = 1'b1;
        cfg_base_line = 43'h999;
        @(negedge clk);
        cfg_base_wr = 1'b0;
        idle(3);
        chk(cfg_next_line == BASE0, "R9 write ignored", 64'(cfg_next_line), 64'(BASE0));

        // R7: saturation at 255
        setup(3, 1'b0, 1'b0);
        cfg_enable = 1'b1;
        ring(300);
        idle(3500);
        chk(n_inst == 255, "R7 stop at 255", 64'(n_inst), 255);
        chk(inflight_count == 8'd255, "R7 inflight full", 64'(inflight_count), 255);
        retire(1);
        idle(40);
        chk(n_inst == 256, "R7 resume after done", 64'(n_inst), 256);
        chk(inflight_count == 8'd255, "R7 refill", 64'(inflight_count), 255);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule